// File: doc/BRIEF.md
# T1 Transmit Channel Byte Processor

This block sits in the transmit data path of a T1 framer. Each time a DS0 channel byte arrives, it rewrites that byte according to the current line mode. It can insert a per-channel signalling bit into the least significant bit position during signalling frames. It applies zero-code suppression by stuffing bit 7, or, when B8ZS is in use, it marks the all-zero byte for a downstream line encoder. It can also force bit 2 low to send a yellow alarm. These rewrites happen in a fixed order: signalling insertion first, zero-code handling second, and yellow-alarm forcing last.

Bits are numbered 1 to 8. Bit 1 is the most significant bit and is sent first, so bit n sits at vector index 8-n. A second, independent path supplies the value for each facility data link bit slot in extended-superframe operation. That value is either the external data link input or a repeating yellow-alarm pattern. Framing bits, CRC and bipolar line coding belong to other blocks.

Top module: `t1_tx_chan_proc`

## Requirements
- R1: When `transparent` is high, no zero-code suppression takes place. An all-zero byte leaves as 0x00, `out_zero` stays low, and `b8zs_active` is low whatever `b8zs_sel` is.
- R2: When `transparent` and `b8zs_sel` are both low, a byte that is all zeros after signalling insertion leaves with bit 7 (index 1) set, giving 0x02.
- R3: When `b8zs_sel` is high and `transparent` is low, `b8zs_active` is high. No bit stuffing takes place. `out_zero` is high exactly for bytes that are all zeros after signalling insertion, and the byte value passes through unchanged.
- R4: When `bit2_alarm` is high, bit 2 (index 6) of every output byte is 0. This forcing is applied after zero-code suppression, so an input of 0x40 leaves as 0x00 and an input of 0x00 leaves as 0x02.
- R5: When `rbs_disable` is low and the frame is a signalling frame, bit 8 (index 0) of the byte is replaced by the selected signalling bit. When `rbs_disable` is high, bit 8 passes through unchanged.
- R6: `sig_abcd` holds A at index 3, B at 2, C at 1 and D at 0. With `esf_mode` low, frame 6 carries A and frame 12 carries B. With `esf_mode` high, frames 6, 12, 18 and 24 carry A, B, C and D. All other frames, including frames 18 and 24 with `esf_mode` low, are left untouched.
- R7: A pulse on `fdl_slot` produces `fdl_valid` one cycle later. Unless the ESF yellow pattern is active, `fdl_out` then equals the `fdl_in` value sampled with that pulse.
- R8: When `esf_mode` and `esf_yellow` are both high, successive FDL slots carry eight ones followed by eight zeros, repeating. The pattern starts with a one on the first slot after it is enabled. With `esf_mode` low, `esf_yellow` has no effect.
- R9: `out_valid` follows `in_valid` by exactly one cycle, and `out_byte` and `out_zero` update with it. After reset, `out_valid`, `out_byte`, `out_zero`, `fdl_valid` and `fdl_out` are 0.
- R10: Signalling insertion happens before the zero check. An all-zero byte that receives a signalling bit of 1 leaves as 0x01, with no stuffing and no `out_zero`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Channel byte present this cycle |
| in_byte | input | 8 | DS0 channel byte, bit 1 at index 7 |
| frame_idx | input | 5 | Frame number within the superframe, 1-based |
| sig_abcd | input | 4 | Signalling bits for this channel, A at index 3 |
| esf_mode | input | 1 | Extended superframe operation |
| transparent | input | 1 | Disable all zero-code suppression |
| b8zs_sel | input | 1 | Select B8ZS instead of bit-7 stuffing |
| bit2_alarm | input | 1 | Force bit 2 low in every byte |
| rbs_disable | input | 1 | Disable robbed-bit signalling insertion |
| esf_yellow | input | 1 | Send yellow pattern on the data link (ESF only) |
| fdl_slot | input | 1 | Current bit position is an FDL slot |
| fdl_in | input | 1 | External data link bit |
| out_valid | output | 1 | Processed byte present |
| out_byte | output | 8 | Processed channel byte |
| out_zero | output | 1 | All-zero byte marker for the B8ZS encoder |
| b8zs_active | output | 1 | B8ZS coding in effect |
| fdl_valid | output | 1 | FDL bit present |
| fdl_out | output | 1 | FDL bit value to transmit |

## Verification
Either the byte path or the data link pattern can hold a wrong internal state. A wrong rewrite order or a wrong frame-to-letter decode shows on `out_byte` in the very next cycle after the affected byte. For example, it can appear as a stuffed 0x02 where 0x01 was due, as a lost bit in the least significant position, or as a zero byte left over after the alarm forcing. A yellow-pattern counter that is misaligned or does not restart shows up only across a run of FDL slots. The phase of the ones and zeros on `fdl_out` drifts from the first slot after enabling, and one full sixteen-slot period is enough to expose it.

// File: rtl/t1tx_pkg.sv
package t1tx_pkg;
  localparam int BYTE_W   = 8;
  localparam int FRAME_W  = 5;
  localparam int SIG_N    = 4;
  localparam int SIG_STEP = 6;

  typedef struct packed {
    logic       hit;
    logic [1:0] idx;
  } sig_sel_t;

  // vector index of transmit bit number n (1 = first sent)
  function automatic int bitpos(input int n);
    return BYTE_W - n;
  endfunction

  // which signalling letter, if any, a frame carries
  function automatic sig_sel_t sig_lookup(input logic [FRAME_W-1:0] frame,
                                          input logic esf,
                                          input int d4_letters,
                                          input int esf_letters);
    sig_sel_t r;
    int f;
    int n;
    int lim;
    f   = int'(frame);
    n   = f / SIG_STEP;
    lim = esf ? esf_letters : d4_letters;
    r.hit = (f != 0) && ((f % SIG_STEP) == 0) && (n <= lim);
    r.idx = r.hit ? 2'(n - 1) : 2'd0;
    return r;
  endfunction

  function automatic logic is_all_zero(input logic [BYTE_W-1:0] b);
    return b == '0;
  endfunction
endpackage

// File: rtl/t1tx_sig_insert.sv
module t1tx_sig_insert
  import t1tx_pkg::*;
#(
  parameter int D4_LETTERS  = 2,
  parameter int ESF_LETTERS = 4
) (
  input  logic [BYTE_W-1:0]  byte_in,
  input  logic [FRAME_W-1:0] frame,
  input  logic               esf,
  input  logic [SIG_N-1:0]   sig_abcd,
  input  logic               rbs_dis,
  output logic [BYTE_W-1:0]  byte_out,
  output logic               rbs_hit,
  output logic               sig_bit
);
  localparam int RBS_POS = BYTE_W - 8;

  sig_sel_t             sel;
  logic [SIG_N-1:0]     letter_vec;

  // reorder so letter k (A = 0) sits at index k
  genvar k;
  generate
    for (k = 0; k < SIG_N; k++) begin : g_letter
      assign letter_vec[k] = sig_abcd[SIG_N-1-k];
    end
  endgenerate

  always_comb begin
    sel      = sig_lookup(frame, esf, D4_LETTERS, ESF_LETTERS);
    rbs_hit  = sel.hit && !rbs_dis;
    sig_bit  = letter_vec[sel.idx];
    byte_out = byte_in;
    if (rbs_hit) byte_out[RBS_POS] = sig_bit;
  end
endmodule

// File: rtl/t1tx_zcs.sv
module t1tx_zcs
  import t1tx_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              transparent,
  input  logic              b8zs_sel,
  input  logic              alarm,
  output logic [BYTE_W-1:0] byte_out,
  output logic              stuff_hit,
  output logic              zero_mark,
  output logic              b8zs_on
);
  localparam int STUFF_POS = BYTE_W - 7;
  localparam int ALARM_POS = BYTE_W - 2;

  logic zero_in;

  always_comb begin
    zero_in   = is_all_zero(byte_in);
    b8zs_on   = b8zs_sel && !transparent;
    stuff_hit = zero_in && !transparent && !b8zs_sel;
    zero_mark = zero_in && b8zs_on;
    byte_out  = byte_in;
    if (stuff_hit) byte_out[STUFF_POS] = 1'b1;
    // alarm forcing is the final rewrite
    if (alarm) byte_out[ALARM_POS] = 1'b0;
  end
endmodule

// File: rtl/t1tx_fdl_src.sv
module t1tx_fdl_src #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fdl_slot,
  input  logic fdl_in,
  input  logic esf_mode,
  input  logic esf_yellow,
  output logic fdl_valid,
  output logic fdl_out,
  output logic pat_on
);
  localparam int PERIOD = 2 * HALF;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] pat_cnt;
  logic             pat_bit;

  always_comb begin
    pat_on  = esf_mode && esf_yellow;
    pat_bit = int'(pat_cnt) < HALF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_cnt   <= '0;
      fdl_valid <= 1'b0;
      fdl_out   <= 1'b0;
    end else begin
      fdl_valid <= fdl_slot;
      if (fdl_slot) fdl_out <= pat_on ? pat_bit : fdl_in;
      if (!pat_on)              pat_cnt <= '0;
      else if (fdl_slot)        pat_cnt <= (pat_cnt == LAST) ? '0 : pat_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/t1_tx_chan_proc.sv
module t1_tx_chan_proc
  import t1tx_pkg::*;
#(
  parameter int D4_LETTERS  = 2,
  parameter int ESF_LETTERS = 4,
  parameter int YEL_HALF    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_byte,
  input  logic [FRAME_W-1:0] frame_idx,
  input  logic [SIG_N-1:0]   sig_abcd,
  input  logic               esf_mode,
  input  logic               transparent,
  input  logic               b8zs_sel,
  input  logic               bit2_alarm,
  input  logic               rbs_disable,
  input  logic               esf_yellow,
  input  logic               fdl_slot,
  input  logic               fdl_in,
  output logic               out_valid,
  output logic [BYTE_W-1:0]  out_byte,
  output logic               out_zero,
  output logic               b8zs_active,
  output logic               fdl_valid,
  output logic               fdl_out
);
  // named internal events for the checker
  logic [BYTE_W-1:0] sig_byte;
  logic [BYTE_W-1:0] zcs_byte;
  logic              rbs_hit;
  logic              sig_bit;
  logic              stuff_hit;
  logic              zero_mark;
  logic              yel_pat_on;

  t1tx_sig_insert #(
    .D4_LETTERS (D4_LETTERS),
    .ESF_LETTERS(ESF_LETTERS)
  ) u_sig (
    .byte_in (in_byte),
    .frame   (frame_idx),
    .esf     (esf_mode),
    .sig_abcd(sig_abcd),
    .rbs_dis (rbs_disable),
    .byte_out(sig_byte),
    .rbs_hit (rbs_hit),
    .sig_bit (sig_bit)
  );

  t1tx_zcs u_zcs (
    .byte_in    (sig_byte),
    .transparent(transparent),
    .b8zs_sel   (b8zs_sel),
    .alarm      (bit2_alarm),
    .byte_out   (zcs_byte),
    .stuff_hit  (stuff_hit),
    .zero_mark  (zero_mark),
    .b8zs_on    (b8zs_active)
  );

  t1tx_fdl_src #(.HALF(YEL_HALF)) u_fdl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fdl_slot  (fdl_slot),
    .fdl_in    (fdl_in),
    .esf_mode  (esf_mode),
    .esf_yellow(esf_yellow),
    .fdl_valid (fdl_valid),
    .fdl_out   (fdl_out),
    .pat_on    (yel_pat_on)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_byte <= zcs_byte;
        out_zero <= zero_mark;
      end else begin
        out_zero <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/t1tx_checker.sv
module t1tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       transparent,
  input logic       b8zs_sel,
  input logic       bit2_alarm,
  input logic       rbs_disable,
  input logic       esf_mode,
  input logic       esf_yellow,
  input logic       fdl_slot,
  input logic       fdl_in,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       out_zero,
  input logic       fdl_valid,
  input logic       fdl_out,
  input logic       rbs_hit,
  input logic       sig_bit
);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_transparent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(transparent && rbs_disable && !bit2_alarm)
      |-> out_byte == $past(in_byte) && !out_zero);
  p_no_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(!transparent && !b8zs_sel && !bit2_alarm) |-> out_byte != 8'h00);
  p_zero_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_zero |-> out_valid && out_byte == 8'h00 && $past(b8zs_sel && !transparent));
  p_alarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(bit2_alarm) |-> !out_byte[6]);
  p_rbs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(rbs_hit) |-> out_byte[0] == $past(sig_bit));
  p_fdl_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fdl_slot |=> fdl_valid);
  p_fdl_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fdl_valid && !$past(esf_mode && esf_yellow) |-> fdl_out == $past(fdl_in));
endmodule

bind t1_tx_chan_proc t1tx_checker chk (.*);

// File: tb/t1_tx_chan_proc_test.sv
module t1_tx_chan_proc_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [4:0] frame_idx = 5'd1;
  logic [3:0] sig_abcd = '0;
  logic       esf_mode = 1'b0, transparent = 1'b0, b8zs_sel = 1'b0;
  logic       bit2_alarm = 1'b0, rbs_disable = 1'b0, esf_yellow = 1'b0;
  logic       fdl_slot = 1'b0, fdl_in = 1'b0;
  logic       out_valid, out_zero, b8zs_active, fdl_valid, fdl_out;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  t1_tx_chan_proc uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent model, written in transmit bit numbers
  function automatic logic [7:0] model(input logic [7:0] b, input int fr);
    logic [7:0] v;
    int letter;
    v = b;
    letter = 0;
    if (fr == 6) letter = 1;
    else if (fr == 12) letter = 2;
    else if (esf_mode && fr == 18) letter = 3;
    else if (esf_mode && fr == 24) letter = 4;
    if (letter != 0 && !rbs_disable) v[8-8] = sig_abcd[4-letter];
    if (v == 8'h00 && !transparent && !b8zs_sel) v[8-7] = 1'b1;
    if (bit2_alarm) v[8-2] = 1'b0;
    return v;
  endfunction

  task automatic send(input string req, input logic [7:0] b, input int fr);
    logic [7:0] exp;
    in_byte = b; frame_idx = 5'(fr); in_valid = 1'b1;
    exp = model(b, fr);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, int'(out_valid), 1);
    check(req, int'(out_byte), int'(exp));
    check(req, int'(out_zero),
          int'(exp == 8'h00 && b8zs_sel && !transparent && !bit2_alarm));
  endtask

  task automatic fdl_bit(input string req, input logic v, input logic exp);
    fdl_in = v; fdl_slot = 1'b1;
    @(negedge clk);
    fdl_slot = 1'b0;
    check(req, int'(fdl_valid), 1);
    check(req, int'(fdl_out), int'(exp));
  endtask

  task automatic t_reset;
    check("R9 reset", int'(out_valid), 0);
    check("R9 reset", int'(out_byte), 0);
    check("R9 reset", int'(out_zero), 0);
    check("R9 reset", int'(fdl_valid), 0);
    check("R9 reset", int'(fdl_out), 0);
  endtask

  task automatic t_stuff;
    send("R2 zero stuffed", 8'h00, 1);
    check("R2 value", int'(out_byte), 8'h02);
    send("R2 nonzero kept", 8'h55, 3);
    @(negedge clk);
    check("R9 idle", int'(out_valid), 0);
  endtask

  task automatic t_transparent;
    transparent = 1'b1; b8zs_sel = 1'b1;
    #1 check("R1 b8zs ignored", int'(b8zs_active), 0);
    send("R1 zero kept", 8'h00, 2);
    check("R1 value", int'(out_byte), 8'h00);
    transparent = 1'b0; b8zs_sel = 1'b0;
  endtask

  task automatic t_b8zs;
    b8zs_sel = 1'b1;
    #1 check("R3 active", int'(b8zs_active), 1);
    send("R3 zero marked", 8'h00, 4);
    check("R3 mark", int'(out_zero), 1);
    send("R3 nonzero", 8'h10, 4);
    b8zs_sel = 1'b0;
  endtask

  task automatic t_alarm;
    bit2_alarm = 1'b1;
    send("R4 bit2 low", 8'hFF, 1);
    check("R4 value", int'(out_byte), 8'hBF);
    send("R4 after zcs", 8'h40, 1);
    check("R4 value", int'(out_byte), 8'h00);
    send("R4 stuff kept", 8'h00, 1);
    check("R4 value", int'(out_byte), 8'h02);
    bit2_alarm = 1'b0;
  endtask

  task automatic t_rbs_d4;
    sig_abcd = 4'b1010;
    send("R10 sig before zero", 8'h00, 6);
    check("R10 value", int'(out_byte), 8'h01);
    send("R6 d4 B", 8'hFF, 12);
    check("R6 value", int'(out_byte), 8'hFE);
    send("R6 d4 frame18 untouched", 8'hFE, 18);
    check("R6 value", int'(out_byte), 8'hFE);
    send("R6 plain frame", 8'hFE, 5);
    rbs_disable = 1'b1;
    send("R5 disabled", 8'h00, 6);
    check("R5 value", int'(out_byte), 8'h02);
    rbs_disable = 1'b0;
  endtask

  task automatic t_rbs_esf;
    esf_mode = 1'b1; sig_abcd = 4'b0110;
    send("R6 esf A", 8'h01, 6);
    check("R6 value", int'(out_byte), 8'h02);
    send("R5 esf B", 8'h00, 12);
    check("R5 value", int'(out_byte), 8'h01);
    send("R6 esf C", 8'hFE, 18);
    check("R6 value", int'(out_byte), 8'hFF);
    send("R6 esf D", 8'hFF, 24);
    check("R6 value", int'(out_byte), 8'hFE);
    esf_mode = 1'b0;
  endtask

  task automatic t_fdl;
    esf_mode = 1'b1;
    fdl_bit("R7 pass one", 1'b1, 1'b1);
    fdl_bit("R7 pass zero", 1'b0, 1'b0);
    esf_mode = 1'b0; esf_yellow = 1'b1;
    fdl_bit("R8 no effect outside esf", 1'b0, 1'b0);
    @(negedge clk);
    esf_mode = 1'b1;
    for (int i = 0; i < 20; i++) begin
      fdl_bit("R8 yellow pattern", 1'b0, ((i % 16) < 8));
      if (i == 3) @(negedge clk);
    end
    esf_yellow = 1'b0;
    @(negedge clk);
    esf_yellow = 1'b1;
    fdl_bit("R8 restart", 1'b0, 1'b1);
    esf_yellow = 1'b0; esf_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_stuff();
    t_transparent();
    t_b8zs();
    t_alarm();
    t_rbs_d4();
    t_rbs_esf();
    t_fdl();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule